// File: doc/BRIEF.md
# Multi-channel down-counting timer unit

This block holds four independent counters behind a small synchronous register bus. Three channels are reloadable down-counters, two 16 bits wide and one 32 bits wide. Each one steps on a tick it selects, either the slow tick or the fast tick. When it passes zero it either reloads itself or wraps to all-ones. It then raises a sticky interrupt line of its own. The fourth counter is a 40-bit free-running up-counter on the fast tick. It has no interrupt.

Both ticks are single-cycle clock enables that come from outside the block. A bus write takes effect at the clock edge where `bus_we` is high. Read data is combinational from `bus_addr`. The bus has no handshake: every access completes in one cycle and cannot be stalled.

Top module: `tmr_unit`

## Requirements
- R1: Word address = {channel[1:0], reg[1:0]}. Channels 0..2 use reg 0 = reload, 1 = live count, 2 = control, 3 = clear. Channel 3 is the free counter, with reg 0 = count bits 31:0 and reg 1 = high word. In control, bit 7 runs the channel, bit 6 picks reload-on-underflow, and bit 3 picks the slow tick (1) or the fast tick (0). A channel whose bit 7 is clear holds its count.
- R2: A running channel in reload mode decrements once per selected tick. The tick that finds the count at zero loads the reload value, so a reload value L gives a period of L+1 ticks.
- R3: With bit 6 clear, the tick that finds zero wraps the count to the all-ones value of the channel's width.
- R4: Channels 0 and 1 are 16 bits wide and channel 2 is 32 bits wide. A count reads back zero-extended to 32 bits. Writes to a live-count register have no effect.
- R5: Writing the reload register of a stopped channel also sets its count. On a running channel, the same write leaves the count untouched and only changes later reloads.
- R6: `irq_o[i]` goes high the cycle after a tick finds channel i at zero. It stays high until the channel is cleared or stopped.
- R7: Any write to a channel's clear register drops its interrupt in the following cycle. An underflow in the same cycle wins, and the interrupt stays high.
- R8: A stopped channel drives its interrupt low from the next cycle on.
- R9: The free counter adds one per fast tick while bit 8 of its high word is set. The high word reads as {bit 8 = run, bits 7:0 = count bits 39:32}. Writing the high word with bit 8 clear stops the counter and zeroes it.
- R10: The free counter ignores the slow tick and never drives any `irq_o` line.
- R11: After reset every count, reload value, control byte and the free counter read zero, and all interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Word address {channel, register} |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for bus_addr |
| slow_tick | input | 1 | Slow count enable |
| fast_tick | input | 1 | Fast count enable |
| irq_o | output | 3 | Sticky underflow interrupt per reloadable channel |

## Verification
The down-count path is driven with reload values, tick counts and modes taken from a table. Short runs that stop before zero show plain decrement. Runs of exactly one or more periods separate a correct reload from an off-by-one period. Runs past zero in wrap mode separate the 16-bit channels from the 32-bit one by the all-ones value each reaches. A channel set to the fast tick but fed only slow ticks shows that tick selection works. Directed cases then cover a reload written mid-run, a clear that lands on an underflow, stop-clears-interrupt, and the free counter's run bit and its blindness to the slow tick.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // word-address register selector inside one channel
  typedef enum logic [1:0] {
    REG_RELOAD = 2'd0,
    REG_COUNT  = 2'd1,
    REG_CTRL   = 2'd2,
    REG_CLEAR  = 2'd3
  } reg_sel_e;

  // free-counter selectors share the same field
  localparam logic [1:0] FREE_LO = 2'd0;
  localparam logic [1:0] FREE_HI = 2'd1;

  // control byte bit positions
  localparam int CTRL_RUN    = 7;
  localparam int CTRL_RELOAD = 6;
  localparam int CTRL_SLOW   = 3;
  localparam int CTRL_W      = 8;

  // run bit of the free counter high word
  localparam int FREE_RUN_BIT = 8;
endpackage

// File: rtl/tmr_downcnt.sv
module tmr_downcnt
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              fast_tick,
  input  logic              wr_reload,
  input  logic              wr_ctrl,
  input  logic              wr_clear,
  input  logic [CNT_W-1:0]  wdata_cnt,
  input  logic [CTRL_W-1:0] wdata_ctrl,
  output logic [CNT_W-1:0]  reload_q,
  output logic [CNT_W-1:0]  count_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              irq_q,
  output logic              run,
  output logic              underflow
);
  logic tick_sel;
  logic at_zero;

  assign run       = ctrl_q[CTRL_RUN];
  assign tick_sel  = ctrl_q[CTRL_SLOW] ? slow_tick : fast_tick;
  assign at_zero   = (count_q == '0);
  assign underflow = run && tick_sel && at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else begin
      if (wr_ctrl)   ctrl_q   <= wdata_ctrl;
      if (wr_reload) reload_q <= wdata_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (wr_reload && !run) begin
      count_q <= wdata_cnt;
    end else if (run && tick_sel) begin
      if (at_zero)
        count_q <= ctrl_q[CTRL_RELOAD] ? reload_q : '1;
      else
        count_q <= count_q - 1'b1;
    end
  end

  // sticky flag: underflow beats a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         irq_q <= 1'b0;
    else if (!run)      irq_q <= 1'b0;
    else if (underflow) irq_q <= 1'b1;
    else if (wr_clear)  irq_q <= 1'b0;
  end
endmodule

// File: rtl/tmr_freecnt.sv
module tmr_freecnt #(
  parameter int CNT_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fast_tick,
  input  logic             wr_hi,
  input  logic             wdata_run,
  output logic             run_q,
  output logic [CNT_W-1:0] count_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      count_q <= '0;
    end else begin
      if (wr_hi) run_q <= wdata_run;
      if (wr_hi && !wdata_run)
        count_q <= '0;
      else if (run_q && fast_tick)
        count_q <= count_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_regmap.sv
module tmr_regmap
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic                         bus_we,
  input  logic [NUM_CH-1:0][DATA_W-1:0] reload_rd,
  input  logic [NUM_CH-1:0][DATA_W-1:0] count_rd,
  input  logic [NUM_CH-1:0][DATA_W-1:0] ctrl_rd,
  input  logic [DATA_W-1:0]            free_lo_rd,
  input  logic [DATA_W-1:0]            free_hi_rd,
  output logic [NUM_CH-1:0]            wr_reload,
  output logic [NUM_CH-1:0]            wr_ctrl,
  output logic [NUM_CH-1:0]            wr_clear,
  output logic                         wr_free_hi,
  output logic [DATA_W-1:0]            bus_rdata
);
  localparam int CH_W = ADDR_W - 2;

  logic [CH_W-1:0] ch_idx;
  reg_sel_e        sel;

  assign ch_idx = bus_addr[ADDR_W-1:2];
  assign sel    = reg_sel_e'(bus_addr[1:0]);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
    logic hit;
    assign hit          = bus_we && (ch_idx == CH_W'(g));
    assign wr_reload[g] = hit && (sel == REG_RELOAD);
    assign wr_ctrl[g]   = hit && (sel == REG_CTRL);
    assign wr_clear[g]  = hit && (sel == REG_CLEAR);
  end

  assign wr_free_hi = bus_we && (ch_idx == CH_W'(NUM_CH)) && (bus_addr[1:0] == FREE_HI);

  always_comb begin
    bus_rdata = '0;
    if (ch_idx == CH_W'(NUM_CH)) begin
      if (bus_addr[1:0] == FREE_LO)      bus_rdata = free_lo_rd;
      else if (bus_addr[1:0] == FREE_HI) bus_rdata = free_hi_rd;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (ch_idx == CH_W'(i)) begin
          case (sel)
            REG_RELOAD: bus_rdata = reload_rd[i];
            REG_COUNT:  bus_rdata = count_rd[i];
            REG_CTRL:   bus_rdata = ctrl_rd[i];
            default:    bus_rdata = '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int NUM_CH  = 3,
  parameter int SHORT_W = 16,
  parameter int LONG_W  = 32,
  parameter int FREE_W  = 40,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              slow_tick,
  input  logic              fast_tick,
  output logic [NUM_CH-1:0] irq_o
);
  localparam int HI_W = FREE_W - DATA_W;

  // last channel is the wide one
  function automatic int ch_width(input int idx);
    return (idx == NUM_CH - 1) ? LONG_W : SHORT_W;
  endfunction

  logic [NUM_CH-1:0][DATA_W-1:0] reload_rd, count_rd, ctrl_rd;
  logic [NUM_CH-1:0]             wr_reload, wr_ctrl, wr_clear;
  logic [NUM_CH-1:0]             en_vec, uf_vec;
  logic [DATA_W-1:0]             free_lo_rd, free_hi_rd;
  logic                          free_hi_wr;
  logic                          free_en;
  logic [FREE_W-1:0]             free_cnt;

  assign clr_vec = wr_clear;
  logic [NUM_CH-1:0] clr_vec;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int CW = ch_width(g);
    logic [CW-1:0]     reload_w, count_w;
    logic [CTRL_W-1:0] ctrl_w;

    tmr_downcnt #(.CNT_W(CW)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .slow_tick  (slow_tick),
      .fast_tick  (fast_tick),
      .wr_reload  (wr_reload[g]),
      .wr_ctrl    (wr_ctrl[g]),
      .wr_clear   (wr_clear[g]),
      .wdata_cnt  (bus_wdata[CW-1:0]),
      .wdata_ctrl (bus_wdata[CTRL_W-1:0]),
      .reload_q   (reload_w),
      .count_q    (count_w),
      .ctrl_q     (ctrl_w),
      .irq_q      (irq_o[g]),
      .run        (en_vec[g]),
      .underflow  (uf_vec[g])
    );

    assign reload_rd[g] = DATA_W'(reload_w);
    assign count_rd[g]  = DATA_W'(count_w);
    assign ctrl_rd[g]   = DATA_W'(ctrl_w);
  end

  tmr_freecnt #(.CNT_W(FREE_W)) u_free (
    .clk       (clk),
    .rst_n     (rst_n),
    .fast_tick (fast_tick),
    .wr_hi     (free_hi_wr),
    .wdata_run (bus_wdata[FREE_RUN_BIT]),
    .run_q     (free_en),
    .count_q   (free_cnt)
  );

  assign free_lo_rd = free_cnt[DATA_W-1:0];
  assign free_hi_rd = DATA_W'({free_en, free_cnt[FREE_W-1 -: HI_W]});

  tmr_regmap #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_map (
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .reload_rd  (reload_rd),
    .count_rd   (count_rd),
    .ctrl_rd    (ctrl_rd),
    .free_lo_rd (free_lo_rd),
    .free_hi_rd (free_hi_rd),
    .wr_reload  (wr_reload),
    .wr_ctrl    (wr_ctrl),
    .wr_clear   (wr_clear),
    .wr_free_hi (free_hi_wr),
    .bus_rdata  (bus_rdata)
  );
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
  parameter int NUM_CH = 3,
  parameter int FREE_W = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] irq_o,
  input logic [NUM_CH-1:0] en_vec,
  input logic [NUM_CH-1:0] uf_vec,
  input logic [NUM_CH-1:0] clr_vec,
  input logic              fast_tick,
  input logic              free_en,
  input logic              free_wr,
  input logic [FREE_W-1:0] free_cnt
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_prop
    // R6: flag stays while running and not cleared
    p_irq_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o[g] && en_vec[g] && !clr_vec[g]) |=> irq_o[g]);
    // R6: flag rises only after an underflow
    p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o[g]) |-> $past(uf_vec[g]));
    // R7: clear without underflow drops the flag
    p_clear_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[g] && !uf_vec[g]) |=> !irq_o[g]);
    // R8: stopped channel holds its flag low
    p_stop_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !en_vec[g] |=> !irq_o[g]);
  end

  // R9: free counter steps by one per fast tick
  p_free_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (free_en && fast_tick && !free_wr) |=> (free_cnt == $past(free_cnt) + 1'b1));
  // R10: without a fast tick the free counter holds
  p_free_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!fast_tick && !free_wr) |=> $stable(free_cnt));
  // R9: a stopped free counter holds
  p_free_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!free_en && !free_wr) |=> $stable(free_cnt));
endmodule

bind tmr_unit tmr_unit_chk #(.NUM_CH(NUM_CH), .FREE_W(FREE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_o     (irq_o),
  .en_vec    (en_vec),
  .uf_vec    (uf_vec),
  .clr_vec   (clr_vec),
  .fast_tick (fast_tick),
  .free_en   (free_en),
  .free_wr   (free_hi_wr),
  .free_cnt  (free_cnt)
);

// File: tb/tmr_unit_tb.sv
module tmr_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic        slow_tick = 1'b0;
  logic        fast_tick = 1'b0;
  logic [2:0]  irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tmr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .slow_tick(slow_tick),
    .fast_tick(fast_tick), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [1:0]  ch;
    logic [31:0] reload;
    logic        periodic;
    logic        slow_sel;
    logic [7:0]  ticks;
    logic [31:0] exp_val;
    logic        exp_irq;
  } vec_t;

  // R2 period, R3 wrap, R4 widths, R1 tick select
  localparam vec_t VECS [8] = '{
    '{2'd0, 32'd4,       1'b1, 1'b1, 8'd3, 32'd1,          1'b0},
    '{2'd0, 32'd4,       1'b1, 1'b1, 8'd5, 32'd4,          1'b1},
    '{2'd1, 32'd2,       1'b1, 1'b1, 8'd7, 32'd1,          1'b1},
    '{2'd2, 32'h10000,   1'b1, 1'b1, 8'd2, 32'h0000FFFE,   1'b0},
    '{2'd0, 32'd1,       1'b0, 1'b1, 8'd3, 32'h0000FFFE,   1'b1},
    '{2'd2, 32'd0,       1'b0, 1'b1, 8'd1, 32'hFFFFFFFF,   1'b1},
    '{2'd1, 32'd5,       1'b1, 1'b0, 8'd4, 32'd5,          1'b0},
    '{2'd1, 32'h0000FFFF,1'b1, 1'b1, 8'd2, 32'h0000FFFD,   1'b0}
  };

  function automatic logic [3:0] ad(input int ch, input int sel);
    return 4'((ch << 2) | sel);
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic slow_pulses(input int n);
    repeat (n) begin
      @(negedge clk); slow_tick = 1'b1;
      @(negedge clk); slow_tick = 1'b0;
    end
  endtask

  task automatic fast_pulses(input int n);
    repeat (n) begin
      @(negedge clk); fast_tick = 1'b1;
      @(negedge clk); fast_tick = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  cb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state
    for (int c = 0; c < 3; c++) begin
      rd(ad(c, 0), d); check("R11 reload", d, 0);
      rd(ad(c, 1), d); check("R11 count", d, 0);
      rd(ad(c, 2), d); check("R11 ctrl", d, 0);
    end
    rd(ad(3, 0), d); check("R11 free lo", d, 0);
    rd(ad(3, 1), d); check("R11 free hi", d, 0);
    check("R11 irq", 32'(irq_o), 0);

    // table walk
    for (int i = 0; i < 8; i++) begin
      cb = {1'b0, VECS[i].periodic, 2'b00, VECS[i].slow_sel, 3'b000};
      wr(ad(VECS[i].ch, 2), 32'(cb));
      wr(ad(VECS[i].ch, 0), VECS[i].reload);
      wr(ad(VECS[i].ch, 2), 32'(cb | 8'h80));
      slow_pulses(int'(VECS[i].ticks));
      rd(ad(VECS[i].ch, 1), d);
      check($sformatf("R2/R3/R4 vec%0d count", i), d, VECS[i].exp_val);
      check($sformatf("R6 vec%0d irq", i), 32'(irq_o[VECS[i].ch]), 32'(VECS[i].exp_irq));
      wr(ad(VECS[i].ch, 2), 32'h0);
    end

    // R1: fast tick selected, stopped channel holds
    wr(ad(0, 2), 32'h40);
    wr(ad(0, 0), 32'd3);
    wr(ad(0, 2), 32'hC0);
    fast_pulses(2);
    rd(ad(0, 1), d); check("R1 fast select", d, 1);
    wr(ad(0, 2), 32'h48);
    slow_pulses(2);
    rd(ad(0, 1), d); check("R1 stopped holds", d, 1);
    // R4: write to count register ignored
    wr(ad(0, 1), 32'h1234);
    rd(ad(0, 1), d); check("R4 count write ignored", d, 1);

    // R5: reload written while running
    wr(ad(0, 0), 32'd5);
    wr(ad(0, 2), 32'hC8);
    slow_pulses(2);
    wr(ad(0, 0), 32'd9);
    rd(ad(0, 1), d); check("R5 running count kept", d, 3);
    slow_pulses(4);
    rd(ad(0, 1), d); check("R5 new reload used", d, 9);
    wr(ad(0, 2), 32'h0);

    // R6/R7: sticky flag and clear
    wr(ad(1, 2), 32'h48);
    wr(ad(1, 0), 32'd0);
    wr(ad(1, 2), 32'hC8);
    slow_pulses(1);
    repeat (3) @(negedge clk);
    check("R6 sticky", 32'(irq_o[1]), 1);
    wr(ad(1, 3), 32'h0);
    check("R7 clear drops", 32'(irq_o[1]), 0);
    @(negedge clk);
    bus_addr = ad(1, 3); bus_we = 1'b1; slow_tick = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; slow_tick = 1'b0;
    check("R7 underflow wins", 32'(irq_o[1]), 1);

    // R8: stopping drops the flag
    wr(ad(1, 2), 32'h48);
    @(negedge clk);
    check("R8 stop drops", 32'(irq_o[1]), 0);

    // R9/R10: free counter
    wr(ad(3, 1), 32'h100);
    fast_pulses(5);
    rd(ad(3, 0), d); check("R9 free lo", d, 5);
    rd(ad(3, 1), d); check("R9 free hi", d, 32'h100);
    slow_pulses(3);
    rd(ad(3, 0), d); check("R10 slow ignored", d, 5);
    check("R10 no irq", 32'(irq_o), 0);
    wr(ad(3, 1), 32'h0);
    fast_pulses(2);
    rd(ad(3, 0), d); check("R9 stop zeroes", d, 0);
    rd(ad(3, 1), d); check("R9 hi stopped", d, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule